// File: doc/BRIEF.md
# Data Hazard Interlock and Operand Bypass Control

This block holds the data-hazard decisions for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the register numbers, write enables and load flags of the instructions in decode, execute, memory and writeback. From these it picks the source of each execute operand and of the store data entering the memory stage. It also decides whether the front of the pipeline must freeze. It is purely combinational. The clock and reset ports serve only the embedded checks.

A static mode input selects one of two policies. With bypassing on, ALU results reach a dependent instruction in execute from the memory or writeback stage. A load costs one bubble to a direct consumer in execute. A store's data operand is exempt from that bubble because its data is patched in the memory stage. With bypassing off, every operand comes from the register file. A dependent instruction then waits in decode until its producer reaches writeback. The register file writes early and reads late in a cycle, so a producer in writeback never forces a wait.

Top module: `hazard_fwd_unit`

## Requirements
- R1: In bypass mode, when the memory-stage instruction writes a nonzero register equal to the execute-stage first source and is not a load, `fwd_a` is 2'b01. `fwd_a`/`fwd_b` encoding: 2'b00 register file, 2'b01 memory-stage result, 2'b10 writeback-stage result; 2'b11 never appears.
- R2: In bypass mode, when only the writeback-stage instruction writes the execute source register (nonzero), the select for that operand (`fwd_a` for the first source, `fwd_b` for the second) is 2'b10.
- R3: When both the memory-stage and writeback-stage instructions write the same execute source, the memory-stage result (2'b01) wins.
- R4: Register 0 never causes a forward or a stall, whatever the stage fields hold.
- R5: In bypass mode, a load in execute writing a nonzero register that the decode instruction reads as first source, or as second source when it is not a store, raises the stall.
- R6: In bypass mode, a store in decode whose data register (second source) matches a load in execute does not stall. A match on its base register (first source) does stall.
- R7: A load in the memory stage is never selected as an execute operand. In bypass mode, `st_fwd` is 1 exactly when a store is in the memory stage and the writeback instruction writes its nonzero data register.
- R8: In interlock mode, all selects are 0. The stall is raised exactly when the execute or memory-stage instruction writes a nonzero register read by decode on either source. A writeback-stage match alone does not stall.
- R9: `hold_pc`, `hold_ifid` and `bubble_ex` are always equal.
- R10: In bypass mode, an ALU producer in execute matching a decode source does not stall.
- R11: The program load, load, dependent add, store of the sum, subtract, branch completes writeback of the branch in cycle 11 with bypassing and in cycle 16 without.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for embedded checks |
| rst_n | input | 1 | Active-low reset for embedded checks |
| bypass_en | input | 1 | 1 = full bypassing, 0 = register-file-only interlock |
| id_rs1 | input | RW | Decode first source (store base) |
| id_rs2 | input | RW | Decode second source (store data) |
| id_st | input | 1 | Decode instruction is a store |
| ex_rs1 | input | RW | Execute first source |
| ex_rs2 | input | RW | Execute second source |
| ex_rd | input | RW | Execute destination |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_ld | input | 1 | Execute instruction is a load |
| mem_rs2 | input | RW | Memory-stage store data register |
| mem_st | input | 1 | Memory-stage instruction is a store |
| mem_rd | input | RW | Memory-stage destination |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_ld | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | RW | Writeback destination |
| wb_wr | input | 1 | Writeback instruction writes a register |
| hold_pc | output | 1 | Freeze the program counter |
| hold_ifid | output | 1 | Freeze the fetch/decode register |
| bubble_ex | output | 1 | Load a no-op into the decode/execute register |
| fwd_a | output | 2 | First execute operand source |
| fwd_b | output | 2 | Second execute operand (and carried store data) source |
| st_fwd | output | 1 | Replace store data in memory stage with writeback result |

## Verification
The store-data patch in the memory stage and a load-use stall in decode can fall in the same cycle. This happens when a load sits in writeback under a store in memory while another load in execute feeds the decode instruction. The bench provokes this with random stage contents drawn from a four-register space, so collisions are frequent. It also runs a small six-instruction program through a pipeline model in the bench. Every cycle, the bench compares each select and the stall against a behavioural reference. It judges the program by the cycle in which the branch retires under each mode.

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bypass_en,
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic          id_st,
  input  logic [RW-1:0] ex_rs1,
  input  logic [RW-1:0] ex_rs2,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_wr,
  input  logic          ex_ld,
  input  logic [RW-1:0] mem_rs2,
  input  logic          mem_st,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wr,
  input  logic          mem_ld,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_wr,
  output logic          hold_pc,
  output logic          hold_ifid,
  output logic          bubble_ex,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          st_fwd
);
  localparam logic [RW-1:0] R_ZERO = '0;
  localparam logic [1:0] SEL_RF = 2'b00, SEL_MEM = 2'b01, SEL_WB = 2'b10;

  function automatic logic hit(input logic wr, input logic [RW-1:0] rd, input logic [RW-1:0] rs);
    return wr && (rd == rs) && (rs != R_ZERO);
  endfunction

  function automatic logic [1:0] pick(input logic [RW-1:0] rs, input logic m_wr,
                                      input logic m_ld, input logic [RW-1:0] m_rd,
                                      input logic w_wr, input logic [RW-1:0] w_rd);
    if (hit(m_wr && !m_ld, m_rd, rs)) return SEL_MEM;
    if (hit(w_wr, w_rd, rs))          return SEL_WB;
    return SEL_RF;
  endfunction

  logic ex_hit1, ex_hit2, mem_hit1, mem_hit2;
  logic load_use, interlock, stall;

  assign ex_hit1  = hit(ex_wr, ex_rd, id_rs1);
  assign ex_hit2  = hit(ex_wr, ex_rd, id_rs2);
  assign mem_hit1 = hit(mem_wr, mem_rd, id_rs1);
  assign mem_hit2 = hit(mem_wr, mem_rd, id_rs2);

  assign load_use  = ex_ld && (ex_hit1 || (ex_hit2 && !id_st));
  assign interlock = ex_hit1 || ex_hit2 || mem_hit1 || mem_hit2;
  assign stall     = bypass_en ? load_use : interlock;

  assign hold_pc   = stall;
  assign hold_ifid = stall;
  assign bubble_ex = stall;

  assign fwd_a  = bypass_en ? pick(ex_rs1, mem_wr, mem_ld, mem_rd, wb_wr, wb_rd) : SEL_RF;
  assign fwd_b  = bypass_en ? pick(ex_rs2, mem_wr, mem_ld, mem_rd, wb_wr, wb_rd) : SEL_RF;
  assign st_fwd = bypass_en && mem_st && hit(wb_wr, wb_rd, mem_rs2);

  a_r1_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11) && (fwd_b != 2'b11));

  a_r3_mem_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == SEL_WB) |-> !(mem_wr && !mem_ld && mem_rd == ex_rs1 && ex_rs1 != R_ZERO));

  a_r4_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1 == R_ZERO && id_rs2 == R_ZERO) |-> !hold_pc);

  a_r5_load_use: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_en && ex_ld && ex_wr && ex_rd != R_ZERO && ex_rd == id_rs1) |-> hold_pc);

  a_r7_no_load_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == SEL_MEM || fwd_b == SEL_MEM) |-> !mem_ld);

  a_r8_interlock_rf: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass_en |-> (fwd_a == SEL_RF && fwd_b == SEL_RF && !st_fwd));

  a_r9_stall_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_pc == hold_ifid) && (hold_ifid == bubble_ex));
endmodule

// File: tb/hazard_fwd_unit_tb.sv
module hazard_fwd_unit_tb;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic bypass_en, id_st, ex_wr, ex_ld, mem_st, mem_wr, mem_ld, wb_wr;
  logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rs2, mem_rd, wb_rd;
  logic hold_pc, hold_ifid, bubble_ex, st_fwd;
  logic [1:0] fwd_a, fwd_b;
  int tests = 0, fails = 0;

  hazard_fwd_unit u_dut (.*);

  // watchdog
  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog: run hung (actual timeout, expected completion)");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ref_sel(int rs);
    if (!bypass_en || rs == 0) return 0;
    if (mem_wr && !mem_ld && mem_rd == rs) return 1;
    if (wb_wr && wb_rd == rs) return 2;
    return 0;
  endfunction

  function automatic int ref_stall();
    int srcs[2];
    srcs[0] = id_rs1; srcs[1] = id_rs2;
    foreach (srcs[i]) begin
      if (srcs[i] == 0) continue;
      if (bypass_en) begin
        if (ex_ld && ex_wr && ex_rd == srcs[i] && !(i == 1 && id_st)) return 1;
      end else begin
        if (ex_wr && ex_rd == srcs[i]) return 1;
        if (mem_wr && mem_rd == srcs[i]) return 1;
      end
    end
    return 0;
  endfunction

  task automatic compare_all();
    int s;
    s = ref_stall();
    chk(bypass_en ? "R1 fwd_a" : "R8 fwd_a", fwd_a, ref_sel(ex_rs1));
    chk(bypass_en ? "R2 fwd_b" : "R8 fwd_b", fwd_b, ref_sel(ex_rs2));
    chk("R7 st_fwd", st_fwd, (bypass_en && mem_st && mem_rs2 != 0 && wb_wr && wb_rd == mem_rs2) ? 1 : 0);
    chk(bypass_en ? "R5 stall" : "R8 stall", hold_pc, s);
    chk("R9 hold_ifid", hold_ifid, hold_pc);
    chk("R9 bubble_ex", bubble_ex, hold_pc);
  endtask

  task automatic clear();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rs2, mem_rd, wb_rd} = '0;
    {id_st, ex_wr, ex_ld, mem_st, mem_wr, mem_ld, wb_wr} = '0;
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
    @(posedge clk); #1;
  endtask

  // program model: rs1, rs2, rd, wr, ld, st
  int p_rs1[6] = '{4, 4, 1, 4, 4, 4};
  int p_rs2[6] = '{0, 0, 2, 3, 0, 0};
  int p_rd [6] = '{1, 2, 3, 0, 4, 0};
  bit p_wr [6] = '{1, 1, 1, 0, 1, 0};
  bit p_ld [6] = '{1, 1, 0, 0, 0, 0};
  bit p_st [6] = '{0, 0, 0, 1, 0, 0};

  task automatic run_prog(bit mode, output int done);
    int fi, di, ei, mi, wi, nxt, cyc;
    fi = 0; di = -1; ei = -1; mi = -1; wi = -1; nxt = 1; cyc = 1; done = 0;
    bypass_en = mode;
    while (cyc < 40 && done == 0) begin
      clear();
      if (di >= 0) begin id_rs1 = 5'(p_rs1[di]); id_rs2 = 5'(p_rs2[di]); id_st = p_st[di]; end
      if (ei >= 0) begin ex_rs1 = 5'(p_rs1[ei]); ex_rs2 = 5'(p_rs2[ei]); ex_rd = 5'(p_rd[ei]);
                         ex_wr = p_wr[ei]; ex_ld = p_ld[ei]; end
      if (mi >= 0) begin mem_rs2 = 5'(p_rs2[mi]); mem_st = p_st[mi]; mem_rd = 5'(p_rd[mi]);
                         mem_wr = p_wr[mi]; mem_ld = p_ld[mi]; end
      if (wi >= 0) begin wb_rd = 5'(p_rd[wi]); wb_wr = p_wr[wi]; end
      @(negedge clk);
      compare_all();
      if (wi == 5) done = cyc;
      wi = mi; mi = ei;
      if (hold_pc) ei = -1;
      else begin
        ei = di; di = fi;
        fi = (nxt < 6) ? nxt : -1;
        if (nxt < 6) nxt++;
      end
      cyc++;
      @(posedge clk); #1;
    end
  endtask

  initial begin
    int done;
    clear(); bypass_en = 1;
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk("R9 reset idle stall", hold_pc, 0);
    chk("R1 reset idle fwd_a", fwd_a, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R3: both stages write ex_rs1
    clear(); bypass_en = 1; ex_rs1 = 3; mem_wr = 1; mem_rd = 3; wb_wr = 1; wb_rd = 3;
    @(negedge clk); chk("R3 priority fwd_a", fwd_a, 1); @(posedge clk); #1;
    // R4: register zero
    clear(); bypass_en = 1; ex_rs1 = 0; mem_wr = 1; mem_rd = 0; ex_wr = 1; ex_ld = 1; ex_rd = 0;
    @(negedge clk); chk("R4 zero fwd", fwd_a, 0); chk("R4 zero stall", hold_pc, 0); @(posedge clk); #1;
    bypass_en = 0; mem_wr = 1; mem_rd = 0;
    @(negedge clk); chk("R4 zero interlock", hold_pc, 0); @(posedge clk); #1;
    // R6: store data vs load
    clear(); bypass_en = 1; id_st = 1; id_rs2 = 7; id_rs1 = 4; ex_wr = 1; ex_ld = 1; ex_rd = 7;
    @(negedge clk); chk("R6 store data no stall", hold_pc, 0); @(posedge clk); #1;
    ex_rd = 4;
    @(negedge clk); chk("R6 store base stall", hold_pc, 1); @(posedge clk); #1;
    // R10: ALU producer in EX
    clear(); bypass_en = 1; id_rs1 = 5; ex_wr = 1; ex_rd = 5;
    @(negedge clk); chk("R10 alu no stall", hold_pc, 0); @(posedge clk); #1;
    // R8: writeback alone no stall
    clear(); bypass_en = 0; id_rs2 = 6; wb_wr = 1; wb_rd = 6;
    @(negedge clk); chk("R8 wb no stall", hold_pc, 0); @(posedge clk); #1;
    mem_wr = 1; mem_rd = 6;
    @(negedge clk); chk("R8 mem stall", hold_pc, 1); @(posedge clk); #1;
    // R7: load in MEM then store data patch
    clear(); bypass_en = 1; ex_rs2 = 2; mem_wr = 1; mem_ld = 1; mem_rd = 2;
    @(negedge clk); chk("R7 no load to ex", fwd_b, 0); @(posedge clk); #1;
    clear(); mem_st = 1; mem_rs2 = 2; wb_wr = 1; wb_rd = 2;
    @(negedge clk); chk("R7 store patch", st_fwd, 1); @(posedge clk); #1;

    // random stage contents, both modes
    for (int n = 0; n < 3000; n++) begin
      bypass_en = (n % 4) != 0;
      id_rs1 = 5'($urandom_range(0, 3)); id_rs2 = 5'($urandom_range(0, 3)); id_st = 1'($urandom);
      ex_rs1 = 5'($urandom_range(0, 3)); ex_rs2 = 5'($urandom_range(0, 3)); ex_rd = 5'($urandom_range(0, 3));
      ex_wr = 1'($urandom); ex_ld = 1'($urandom);
      mem_rs2 = 5'($urandom_range(0, 3)); mem_st = 1'($urandom); mem_rd = 5'($urandom_range(0, 3));
      mem_wr = 1'($urandom); mem_ld = 1'($urandom);
      wb_rd = 5'($urandom_range(0, 3)); wb_wr = 1'($urandom);
      step();
    end

    run_prog(1'b1, done);
    chk("R11 bypass program cycles", done, 11);
    run_prog(1'b0, done);
    chk("R11 interlock program cycles", done, 16);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule